// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit performs the basic bit-manipulation operations of a 32-bit RISC-V integer pipeline. Each cycle it takes two operands, a 5-bit immediate rotate amount and an operation code. It returns one result word. The operations are:

- logic with an inverted second operand
- counts of leading zeros, trailing zeros and set bits
- signed and unsigned minimum and maximum
- sign and zero extension
- rotates by register or by immediate
- a per-byte OR-reduce
- byte-order reversal

A small control module decodes the operation code into a strobe struct. A datapath module computes all operation families and selects one result.

The parameter `REG_OUT` chooses the output timing. With the default value of 1, the result is captured in an output register together with a valid flag. The result then appears one cycle after the request. With `REG_OUT` set to 0 the unit is purely combinational, and the valid flag follows the input valid. Instruction decode, the register file and the 64-bit word variants belong to the surrounding pipeline.

Top module: `bitmanip_unit`

## Requirements
- R1: Code 0 returns opA & ~opB, code 1 returns opA | ~opB, and code 2 returns ~(opA ^ opB).
- R2: Code 3 returns the number of zero bits above the highest set bit of opA, counted from bit 31. It returns 32 when opA is zero.
- R3: Code 4 returns the number of zero bits below the lowest set bit of opA, counted from bit 0. It returns 32 when opA is zero.
- R4: Code 5 returns the number of set bits in opA. It returns 0 for a zero operand.
- R5: Codes 6 and 8 return the signed maximum and signed minimum of opA and opB. Codes 7 and 9 return the unsigned maximum and unsigned minimum.
- R6: Code 10 copies bit 7 of opA into bits 31:8. Code 11 copies bit 15 into bits 31:16. Code 12 keeps bits 15:0 and clears bits 31:16.
- R7: Code 13 rotates opA left and code 14 rotates opA right, each by opB[4:0]. The upper bits of opB are ignored.
- R8: Code 15 rotates opA right by immAmt. An amount of 0 returns opA unchanged.
- R9: Code 16 sets each result byte to 0xFF when the matching byte of opA is nonzero, and to 0x00 when it is zero.
- R10: Code 17 returns opA with its four bytes in reverse order.
- R11: Codes 18 to 31 return zero.
- R12: With REG_OUT=1, a request accepted with inValid high produces outValid high and its result one clock later. While inValid is low, outValid is low and result holds its last value. Reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 5 | Operation code (see requirements) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand or rotate amount |
| immAmt | input | 5 | Immediate rotate amount |
| outValid | output | 1 | Result valid |
| result | output | 32 | Operation result |

## Verification
The unit has no state beyond its output stage, so any fault in decode or in an arithmetic family shows as a wrong `result` exactly one cycle after the request. The fault shows only for the operation codes that reach the faulty path. The bench therefore compares every cycle against a behavioural model. It runs each code at its edge operands: all-zero, all-ones, single set bits, sign boundaries, and rotate amounts of 0 and 31. A fault in the output stage shows as a `result` that changes or a valid flag that stays high during an idle cycle.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [4:0] {
    OP_ANDN  = 5'd0,
    OP_ORN   = 5'd1,
    OP_XNOR  = 5'd2,
    OP_CLZ   = 5'd3,
    OP_CTZ   = 5'd4,
    OP_CPOP  = 5'd5,
    OP_MAX   = 5'd6,
    OP_MAXU  = 5'd7,
    OP_MIN   = 5'd8,
    OP_MINU  = 5'd9,
    OP_SEXTB = 5'd10,
    OP_SEXTH = 5'd11,
    OP_ZEXTH = 5'd12,
    OP_ROL   = 5'd13,
    OP_ROR   = 5'd14,
    OP_RORI  = 5'd15,
    OP_ORCB  = 5'd16,
    OP_REV8  = 5'd17
  } op_e;

  typedef enum logic [2:0] {
    U_NONE  = 3'd0,
    U_LOGIC = 3'd1,
    U_COUNT = 3'd2,
    U_CMP   = 3'd3,
    U_EXT   = 3'd4,
    U_ROT   = 3'd5,
    U_BYTE  = 3'd6
  } unit_e;

  typedef struct packed {
    unit_e      unit;
    logic [1:0] sub;
    logic       useImm;
    logic       rotLeft;
    logic       isSigned;
    logic       wantMax;
  } ctrl_t;

endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic [4:0] opSel,
  output ctrl_t      strobes
);

  always_comb begin
    strobes = '0;
    strobes.unit = U_NONE;
    case (opSel)
      OP_ANDN:  begin strobes.unit = U_LOGIC; strobes.sub = 2'd0; end
      OP_ORN:   begin strobes.unit = U_LOGIC; strobes.sub = 2'd1; end
      OP_XNOR:  begin strobes.unit = U_LOGIC; strobes.sub = 2'd2; end
      OP_CLZ:   begin strobes.unit = U_COUNT; strobes.sub = 2'd0; end
      OP_CTZ:   begin strobes.unit = U_COUNT; strobes.sub = 2'd1; end
      OP_CPOP:  begin strobes.unit = U_COUNT; strobes.sub = 2'd2; end
      OP_MAX:   begin strobes.unit = U_CMP; strobes.isSigned = 1'b1; strobes.wantMax = 1'b1; end
      OP_MAXU:  begin strobes.unit = U_CMP; strobes.wantMax = 1'b1; end
      OP_MIN:   begin strobes.unit = U_CMP; strobes.isSigned = 1'b1; end
      OP_MINU:  begin strobes.unit = U_CMP; end
      OP_SEXTB: begin strobes.unit = U_EXT; strobes.sub = 2'd0; end
      OP_SEXTH: begin strobes.unit = U_EXT; strobes.sub = 2'd1; end
      OP_ZEXTH: begin strobes.unit = U_EXT; strobes.sub = 2'd2; end
      OP_ROL:   begin strobes.unit = U_ROT; strobes.rotLeft = 1'b1; end
      OP_ROR:   begin strobes.unit = U_ROT; end
      OP_RORI:  begin strobes.unit = U_ROT; strobes.useImm = 1'b1; end
      OP_ORCB:  begin strobes.unit = U_BYTE; strobes.sub = 2'd0; end
      OP_REV8:  begin strobes.unit = U_BYTE; strobes.sub = 2'd1; end
      default:  strobes.unit = U_NONE;
    endcase
  end

endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int W = 32
) (
  input  ctrl_t                  strobes,
  input  logic [W-1:0]           opA,
  input  logic [W-1:0]           opB,
  input  logic [$clog2(W)-1:0]   immAmt,
  output logic [W-1:0]           res
);

  localparam int SW = $clog2(W);
  localparam int CW = SW + 1;
  localparam int NB = W / 8;

  logic [W-1:0]  logicRes, countRes, cmpRes, extRes, rotRes, byteRes;
  logic [CW-1:0] leadZeros, trailZeros, popCount;
  logic [SW-1:0] rotAmt;
  logic [2*W-1:0] rotWide;
  logic [W-1:0]  orcBytes, revBytes;
  logic          aLess;

  // logic with inverted operand
  always_comb begin
    case (strobes.sub)
      2'd0:    logicRes = opA & ~opB;
      2'd1:    logicRes = opA | ~opB;
      2'd2:    logicRes = ~(opA ^ opB);
      default: logicRes = '0;
    endcase
  end

  // counting: later hits overwrite earlier ones
  always_comb begin
    leadZeros  = CW'(W);
    trailZeros = CW'(W);
    popCount   = '0;
    for (int i = 0; i < W; i++) begin
      if (opA[i]) leadZeros = CW'(W - 1 - i);
      if (opA[W-1-i]) trailZeros = CW'(W - 1 - i);
      popCount = popCount + CW'(opA[i]);
    end
  end

  always_comb begin
    case (strobes.sub)
      2'd0:    countRes = W'(leadZeros);
      2'd1:    countRes = W'(trailZeros);
      2'd2:    countRes = W'(popCount);
      default: countRes = '0;
    endcase
  end

  // min / max
  always_comb begin
    if (strobes.isSigned) aLess = $signed(opA) < $signed(opB);
    else                  aLess = opA < opB;
    if (strobes.wantMax) cmpRes = aLess ? opB : opA;
    else                 cmpRes = aLess ? opA : opB;
  end

  // extension
  always_comb begin
    case (strobes.sub)
      2'd0:    extRes = {{(W-8){opA[7]}}, opA[7:0]};
      2'd1:    extRes = {{(W-16){opA[15]}}, opA[15:0]};
      2'd2:    extRes = {{(W-16){1'b0}}, opA[15:0]};
      default: extRes = '0;
    endcase
  end

  // rotate through a doubled word
  always_comb begin
    rotAmt = strobes.useImm ? immAmt : opB[SW-1:0];
    if (strobes.rotLeft) begin
      rotWide = {opA, opA} << rotAmt;
      rotRes  = rotWide[2*W-1:W];
    end else begin
      rotWide = {opA, opA} >> rotAmt;
      rotRes  = rotWide[W-1:0];
    end
  end

  // byte-wise operations
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign orcBytes[8*b +: 8] = {8{|opA[8*b +: 8]}};
    assign revBytes[8*b +: 8] = opA[8*(NB-1-b) +: 8];
  end

  assign byteRes = (strobes.sub == 2'd0) ? orcBytes :
                   (strobes.sub == 2'd1) ? revBytes : '0;

  always_comb begin
    case (strobes.unit)
      U_LOGIC: res = logicRes;
      U_COUNT: res = countRes;
      U_CMP:   res = cmpRes;
      U_EXT:   res = extRes;
      U_ROT:   res = rotRes;
      U_BYTE:  res = byteRes;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bmu_pkg::*;
#(
  parameter int W       = 32,
  parameter int REG_OUT = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [4:0]           opSel,
  input  logic [W-1:0]         opA,
  input  logic [W-1:0]         opB,
  input  logic [$clog2(W)-1:0] immAmt,
  output logic                 outValid,
  output logic [W-1:0]         result
);

  ctrl_t        strobes;
  logic [W-1:0] combRes;

  bmu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  bmu_datapath #(.W(W)) u_dp (
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .immAmt  (immAmt),
    .res     (combRes)
  );

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outValid <= 1'b0;
        result   <= '0;
      end else begin
        outValid <= inValid;
        if (inValid) result <= combRes;
      end
    end
  end else begin : g_comb
    logic unusedClk;
    assign unusedClk = clk ^ rstN;
    assign outValid  = inValid;
    assign result    = combRes;
  end

endmodule

// File: rtl/bitmanip_unit_checker.sv
module bitmanip_unit_checker #(
  parameter int W       = 32,
  parameter int REG_OUT = 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [4:0]           opSel,
  input logic [W-1:0]         opA,
  input logic [$clog2(W)-1:0] immAmt,
  input logic                 outValid,
  input logic [W-1:0]         result
);

  if (REG_OUT != 0) begin : g_chk
    p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> (!outValid && $stable(result)));

    p_clz_range_r2: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == 5'd3) |=> (result <= W));

    p_ctz_range_r3: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == 5'd4) |=> (result <= W));

    p_cpop_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == 5'd5 && opA == '0) |=> (result == '0));

    p_rori_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == 5'd15 && immAmt == '0) |=> (result == $past(opA)));

    p_orcb_weight_r9: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == 5'd16) |=> ($countones(result) % 8 == 0));

    p_rev8_pop_r10: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == 5'd17) |=> ($countones(result) == $countones($past(opA))));

    p_unknown_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel > 5'd17) |=> (result == '0));
  end

endmodule

bind bitmanip_unit bitmanip_unit_checker #(.W(W), .REG_OUT(REG_OUT)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opSel    (opSel),
  .opA      (opA),
  .immAmt   (immAmt),
  .outValid (outValid),
  .result   (result)
);

// File: tb/bitmanip_unit_bench.sv
module bitmanip_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [4:0]  opSel = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  immAmt = '0;
  logic        outValid;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  logic        expValid = 1'b0;
  logic [31:0] expRes = '0;
  string       expTag = "R12";

  always #2.5 clk = ~clk;

  bitmanip_unit u_bitmanip_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .immAmt(immAmt),
    .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                        input logic [31:0] b, input int imm);
    int n;
    int amt;
    logic [31:0] r;
    r = 0;
    case (op)
      0: r = a & ~b;
      1: r = a | ~b;
      2: r = ~(a ^ b);
      3: begin n = 0; while (n < 32 && !a[31-n]) n++; r = n; end
      4: begin n = 0; while (n < 32 && !a[n]) n++; r = n; end
      5: begin n = 0; for (int i = 0; i < 32; i++) n += a[i]; r = n; end
      6: r = ($signed(a) > $signed(b)) ? a : b;
      7: r = (a > b) ? a : b;
      8: r = ($signed(a) < $signed(b)) ? a : b;
      9: r = (a < b) ? a : b;
      10: r = {{24{a[7]}}, a[7:0]};
      11: r = {{16{a[15]}}, a[15:0]};
      12: r = {16'h0, a[15:0]};
      13, 14, 15: begin
        amt = (op == 15) ? imm : int'(b[4:0]);
        r = a;
        for (int k = 0; k < amt; k++)
          r = (op == 13) ? {r[30:0], r[31]} : {r[0], r[31:1]};
      end
      16: for (int k = 0; k < 4; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
      17: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tagOf(input int op);
    if (op <= 2) return "R1";
    if (op == 3) return "R2";
    if (op == 4) return "R3";
    if (op == 5) return "R4";
    if (op <= 9) return "R5";
    if (op <= 12) return "R6";
    if (op <= 14) return "R7";
    if (op == 15) return "R8";
    if (op == 16) return "R9";
    if (op == 17) return "R10";
    return "R11";
  endfunction

  task automatic compareNow();
    checks++;
    if (outValid !== expValid || result !== expRes) begin
      failures++;
      $display("FAIL %s: valid=%0b result=%08h expected valid=%0b result=%08h",
               expTag, outValid, result, expValid, expRes);
    end
  endtask

  // drive at negedge, check the previous cycle's request at the next negedge
  task automatic step(input logic v, input int op, input logic [31:0] a,
                      input logic [31:0] b, input int imm);
    @(negedge clk);
    compareNow();
    inValid = v;
    opSel   = op[4:0];
    opA     = a;
    opB     = b;
    immAmt  = imm[4:0];
    expValid = v;
    if (v) begin
      expRes = model(op, a, b, imm);
      expTag = tagOf(op);
    end else begin
      expTag = "R12";
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: valid=%0b result=%08h expected completion", outValid, result);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state (R12)
    inValid = 1'b1; opSel = 5'd2; opA = 32'h1234_5678;
    repeat (3) @(negedge clk);
    expValid = 1'b0; expRes = '0; expTag = "R12";
    compareNow();
    inValid = 1'b0;
    rstN = 1'b1;
    // R1
    step(1, 0, 32'hF0, 32'hCC, 0);
    step(1, 1, 32'hF0, 32'hCC, 0);
    step(1, 2, 32'hF0, 32'hCC, 0);
    // R2 / R3 / R4
    step(1, 3, 32'h0100_0000, 0, 0);
    step(1, 3, 32'h0, 0, 0);
    step(1, 3, 32'h8000_0000, 0, 0);
    step(1, 4, 32'h0000_1000, 0, 0);
    step(1, 4, 32'h0, 0, 0);
    step(1, 4, 32'h8000_0000, 0, 0);
    step(1, 5, 32'hD5, 0, 0);
    step(1, 5, 32'h0, 0, 0);
    step(1, 5, 32'hFFFF_FFFF, 0, 0);
    // R5
    step(1, 6, 32'd10, 32'hFFFF_FFFB, 0);
    step(1, 8, 32'd10, 32'hFFFF_FFFB, 0);
    step(1, 7, 32'd10, 32'hFFFF_FFFB, 0);
    step(1, 9, 32'd10, 32'hFFFF_FFFB, 0);
    step(1, 6, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    // R6
    step(1, 10, 32'hFF, 0, 0);
    step(1, 10, 32'h1234_567F, 0, 0);
    step(1, 11, 32'hFFFF, 0, 0);
    step(1, 12, 32'hFFFF_FFFF, 0, 0);
    // R7 / R8
    step(1, 13, 32'h8000_0001, 32'd1, 0);
    step(1, 14, 32'h8000_0001, 32'd1, 0);
    step(1, 13, 32'h8000_0001, 32'hFFFF_FFE1, 0);
    step(1, 14, 32'h1234_5678, 32'd31, 0);
    step(1, 15, 32'h8000_0001, 0, 1);
    step(1, 15, 32'hDEAD_BEEF, 32'd7, 0);
    step(1, 15, 32'h1234_5678, 0, 31);
    // R9 / R10 / R11
    step(1, 16, 32'h0001_0002, 0, 0);
    step(1, 16, 32'h8000_0000, 0, 0);
    step(1, 17, 32'h0123_4567, 0, 0);
    step(1, 18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3);
    step(1, 31, 32'h1234_5678, 32'h0, 0);
    // R12: idle cycles hold result, valid drops
    step(0, 0, 32'hAAAA_AAAA, 32'h5555_5555, 0);
    step(1, 17, 32'hCAFE_F00D, 0, 0);
    step(0, 5, 32'hFFFF_FFFF, 0, 0);
    step(0, 13, 32'h1, 32'h3, 0);
    // mixed random stream
    for (int n = 0; n < 2000; n++) begin
      int op;
      logic [31:0] a;
      op = $urandom_range(0, 19);
      a = $urandom();
      if (n % 5 == 0) a = a & (32'h1 << $urandom_range(0, 31));
      step(($urandom_range(0, 7) != 0), op, a, $urandom(), $urandom_range(0, 31));
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    compareNow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule